// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Register

This block holds the 32-bit interrupt pending word for one processor. The system router drives per-bit set and clear requests to record hardware interrupt levels in the word. Software reaches the word through a small port with one word-wide register per offset. At one offset it reads the word back. At a second offset it writes ones to clear soft bits. At a third offset it writes ones to set soft bits. Only the upper fifteen bits (31:17) can be changed by software. A software clear that names bit 14 also clears bit 31.

The pending word leaves the block as a registered vector. The router folds bits 31:17 of it into the processor's priority-level vector. The chip places one copy of this block per processor, each at its own page-aligned base, and decodes a 16-byte window down to the 2-bit word offset. A write strobe lasts one clock. Read data is registered, so it appears one clock after the offset is presented and always shows the word as it stands after the previous edge.

Top module: `cpu_softirq_reg`

## Requirements
- R1: After a synchronous reset, `pend` and `rd_data` are both zero.
- R2: `rd_data` equals `pend` one clock after `rd_off` is 0. For `rd_off` equal to 1, 2 or 3, `rd_data` is zero one clock later.
- R3: A write at offset 2 ORs `wr_data & 0xFFFE0000` into the pending word at the next clock edge.
- R4: A write at offset 1 clears the pending bits where `wr_data & 0xFFFE0000` has ones, at the next clock edge.
- R5: A write at offset 1 with bit 14 (0x00004000) of `wr_data` set also clears bit 31, whether or not bit 31 of the data is set.
- R6: Software writes never change bits 16:0 of the pending word.
- R7: Writes at offsets 0 and 3 leave the pending word unchanged.
- R8: `hw_set[i]` sets bit i and `hw_clr[i]` clears bit i, for any bit 0..31, at the next edge. When both are high for the same bit, the set wins.
- R9: When a software write and a hardware request act on the same bit in the same cycle, the hardware request decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-clock write strobe |
| wr_off | input | 2 | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_off | input | 2 | Word offset of the read |
| rd_data | output | 32 | Registered read data |
| hw_set | input | 32 | Per-bit hardware set requests from the router |
| hw_clr | input | 32 | Per-bit hardware clear requests from the router |
| pend | output | 32 | Registered pending word to the router |

## Verification
A software write and a router request can fall on the same clock, and they can target the same bit. The bench provokes this by driving a clear write together with a hardware set on one soft bit, and a set write together with a hardware clear on another. Both outcomes are judged against a bench model that applies the software update first and the hardware request last. The full read-back word is compared, so bits the collision should not touch are checked as well.

// File: rtl/cpu_softirq_pkg.sv
package cpu_softirq_pkg;
  localparam int OFF_W = 2;

  typedef enum logic [OFF_W-1:0] {
    OFF_PEND = 2'd0,
    OFF_CLR  = 2'd1,
    OFF_SET  = 2'd2,
    OFF_NONE = 2'd3
  } reg_off_e;
endpackage

// File: rtl/softirq_wr_decode.sv
module softirq_wr_decode
  import cpu_softirq_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  SOFT_MASK = 32'hFFFE_0000,
  parameter int                 LINK_SRC  = 14,
  parameter int                 LINK_DST  = 31
) (
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] clr_mask
);
  localparam logic [DATA_W-1:0] LINK_BIT = DATA_W'(1) << LINK_DST;

  logic [DATA_W-1:0] clr_raw;

  always_comb begin
    clr_raw = wr_data;
    if (wr_data[LINK_SRC]) clr_raw = clr_raw | LINK_BIT;
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (wr_en && (wr_off == OFF_SET)) set_mask = wr_data & SOFT_MASK;
    if (wr_en && (wr_off == OFF_CLR)) clr_mask = clr_raw & SOFT_MASK;
  end
endmodule

// File: rtl/softirq_pend_store.sv
module softirq_pend_store #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw_set,
  input  logic [DATA_W-1:0] sw_clr,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic [DATA_W-1:0] pend_q
);
  logic [DATA_W-1:0] after_sw;
  logic [DATA_W-1:0] pend_d;

  // software first, router last
  always_comb begin
    after_sw = (pend_q | sw_set) & ~sw_clr;
    pend_d   = (after_sw & ~hw_clr) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  p_hw_set_r8: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

  p_hw_clr_r8: assert property (@(posedge clk) disable iff (rst)
    ((hw_clr & ~hw_set) != '0) |=> ((pend_q & $past(hw_clr & ~hw_set)) == '0));

  p_low_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (((hw_set | hw_clr) & ~SOFT_MASK) == '0) |=> ((pend_q & ~SOFT_MASK) == ($past(pend_q) & ~SOFT_MASK)));

  p_sw_set_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_set != '0) |=> ((pend_q & $past(sw_set & ~hw_clr)) == $past(sw_set & ~hw_clr)));

  p_sw_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_clr != '0) |=> ((pend_q & $past(sw_clr & ~hw_set)) == '0));
endmodule

// File: rtl/softirq_rd_port.sv
module softirq_rd_port
  import cpu_softirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst)                     rd_q <= '0;
    else if (rd_off == OFF_PEND) rd_q <= pend_q;
    else                         rd_q <= '0;
  end

  p_rd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_off != OFF_PEND) |=> (rd_q == '0));

  p_rd_word_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_off == OFF_PEND) |=> (rd_q == $past(pend_q)));
endmodule

// File: rtl/cpu_softirq_reg.sv
module cpu_softirq_reg
  import cpu_softirq_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000,
  parameter int                LINK_SRC  = 14,
  parameter int                LINK_DST  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic [DATA_W-1:0] pend
);
  logic [DATA_W-1:0] sw_set_m;
  logic [DATA_W-1:0] sw_clr_m;

  softirq_wr_decode #(
    .DATA_W(DATA_W), .SOFT_MASK(SOFT_MASK),
    .LINK_SRC(LINK_SRC), .LINK_DST(LINK_DST)
  ) u_dec (
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .set_mask(sw_set_m), .clr_mask(sw_clr_m)
  );

  softirq_pend_store #(.DATA_W(DATA_W), .SOFT_MASK(SOFT_MASK)) u_store (
    .clk(clk), .rst(rst),
    .sw_set(sw_set_m), .sw_clr(sw_clr_m),
    .hw_set(hw_set), .hw_clr(hw_clr),
    .pend_q(pend)
  );

  softirq_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_off(rd_off),
    .pend_q(pend), .rd_q(rd_data)
  );

  p_link_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_off == 2'd1 && wr_data[LINK_SRC] && !hw_set[LINK_DST]) |=> !pend[LINK_DST]);

  p_dead_offsets_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_off == 2'd0 || wr_off == 2'd3) && hw_set == '0 && hw_clr == '0) |=> $stable(pend));
endmodule

// File: tb/cpu_softirq_reg_tb.sv
module cpu_softirq_reg_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_off;
  logic [31:0] wr_data;
  logic [1:0]  rd_off;
  logic [31:0] rd_data;
  logic [31:0] hw_set;
  logic [31:0] hw_clr;
  logic [31:0] pend;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_w = '0;

  always #10 clk = ~clk;

  cpu_softirq_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_off(rd_off), .rd_data(rd_data), .hw_set(hw_set), .hw_clr(hw_clr), .pend(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // model: soft bits 31:17, bit14 in clear data also clears 31, hw after sw, hw set beats hw clear
  function automatic logic [31:0] model(input logic [31:0] cur, input logic we, input logic [1:0] off,
                                        input logic [31:0] d, input logic [31:0] hs, input logic [31:0] hc);
    logic [31:0] s = '0;
    logic [31:0] c = '0;
    if (we && off == 2'd2) s = d & 32'hFFFE_0000;
    if (we && off == 2'd1) c = (d | (d[14] ? 32'h8000_0000 : 32'h0)) & 32'hFFFE_0000;
    return (((cur | s) & ~c) & ~hc) | hs;
  endfunction

  task automatic op(input string req, input logic we, input logic [1:0] off,
                    input logic [31:0] d, input logic [31:0] hs, input logic [31:0] hc);
    wr_en = we; wr_off = off; wr_data = d; hw_set = hs; hw_clr = hc; rd_off = 2'd0;
    exp_w = model(exp_w, we, off, d, hs, hc);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; hw_set = '0; hw_clr = '0;
    chk(req, pend, exp_w);
    @(posedge clk); @(negedge clk);
    chk({req, " R2 readback"}, rd_data, exp_w);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_off = '0; wr_data = '0; rd_off = '0; hw_set = '0; hw_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 pend", pend, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);

    // R3 / R6: set each bit singly
    for (int b = 0; b < 32; b++) op("R3 R6 set sweep", 1'b1, 2'd2, 32'h1 << b, '0, '0);
    op("R3 set all", 1'b1, 2'd2, 32'hFFFF_FFFF, '0, '0);
    chk("R6 low bits", pend & 32'h0001_FFFF, 32'h0);

    // R2: other offsets read zero
    for (int o = 1; o < 4; o++) begin
      rd_off = 2'(o);
      @(posedge clk); @(negedge clk);
      chk("R2 zero offset", rd_data, 32'h0);
    end
    rd_off = 2'd0;

    // R7: dead offsets
    op("R7 off0", 1'b1, 2'd0, 32'h0000_0000, '0, '0);
    op("R7 off3 clr-like", 1'b1, 2'd3, 32'hFFFF_FFFF, '0, '0);
    op("R7 off0 ones", 1'b1, 2'd0, 32'hFFFF_FFFF, '0, '0);

    // R4 / R5: clear sweep
    for (int b = 0; b < 32; b++) begin
      op("R4 R5 clear sweep", 1'b1, 2'd1, 32'h1 << b, '0, '0);
      if (b == 14) chk("R5 bit31 cleared by bit14", {31'h0, pend[31]}, 32'h0);
      op("R3 refill", 1'b1, 2'd2, 32'hFFFE_0000, '0, '0);
    end

    // R6: hw-set low bits survive software writes
    op("R8 hw set low", 1'b0, 2'd0, '0, 32'h0001_FFFF, '0);
    op("R6 clear all", 1'b1, 2'd1, 32'hFFFF_FFFF, '0, '0);
    op("R6 set all again", 1'b1, 2'd2, 32'hFFFF_FFFF, '0, '0);

    // R8: hw sweep
    for (int b = 0; b < 32; b++) op("R8 hw clr sweep", 1'b0, 2'd0, '0, '0, 32'h1 << b);
    for (int b = 0; b < 32; b++) op("R8 hw set sweep", 1'b0, 2'd0, '0, 32'h1 << b, '0);
    op("R8 set beats clr", 1'b0, 2'd0, '0, 32'h0000_0100, 32'h0000_0300);

    // R9 collisions
    op("R9 sw clr vs hw set", 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0010_0000, '0);
    op("R9 sw set vs hw clr", 1'b1, 2'd2, 32'hFFFF_FFFF, '0, 32'h0400_0000);
    op("R9 R5 link vs hw set 31", 1'b1, 2'd1, 32'h0000_4000, 32'h8000_0000, '0);

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; exp_w = '0;
    chk("R1 re-reset", pend, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule